// File: doc/BRIEF.md
# Smart-card T=0 character receiver

This block receives asynchronous characters from a smart card over one shared, open-drain I/O line. Each character is a low start bit, eight data bits sent least significant bit first, and one even parity bit. Two guard times follow before the next start bit. Each bit lasts one elementary time unit (ETU). An external tick strobe divides the ETU into `ETU_TICKS` equal steps. The receiver samples each bit at its middle. It confirms a start bit only if the line is still low half an ETU after the first low sample.

When parity fails, the receiver tells the card by pulling the line low for one ETU inside the guard time. The card is then expected to send the character again. The block keeps a saturating error tally that clears when it is read. Error signalling can be suppressed, in which case a sticky flag records the suppressed error. The number of back-to-back error signals can also be capped: once the cap is reached, the next corrupted copy is passed on as a valid character and a second sticky flag records it.

Characters leave the block on a one-entry valid/ready output. The line cannot be stalled, so back-pressure works by dropping characters. While `rx_valid` is high and `rx_ready` is low, the held character and `rx_valid` stay unchanged, and any character completed in that time is discarded. A handshake (`rx_valid` and `rx_ready` both high) frees the entry in the same cycle. A character completing in that cycle is written into the entry.

Top module: `t0_char_rx`

## Requirements
- R1: A frame is a low start bit, data bits D0 first through D7, and a parity bit that makes the count of ones over data and parity even. Each bit is sampled at mid-ETU. A character with correct parity appears on `rx_data` (D0 in bit 0) with `rx_valid` high.
- R2: If the line is high again half an ETU after a low sample seen while idle, that low is ignored. No character, error signal or count change results.
- R3: On a parity error with `cfg_inhibit_nack` low, and the successive-error cap not yet reached, `io_drive_low` is high for exactly one ETU. It rises half an ETU after the parity bit's centre sample, which is 10 ETU after the start bit's first low sample. A character with correct parity never drives the line.
- R4: `err_count` goes up by one for every character with a parity error, whatever the configuration. It saturates at 255 and does not wrap.
- R5: A one-cycle `err_cnt_rd` pulse clears `err_count` to 0. If an error is counted in the same cycle as the read, the result is 1.
- R6: With `cfg_inhibit_nack` high, a parity error drives nothing on the line and sets the sticky flag `nack_inh_flag`.
- R7: `nack_inh_flag` clears only on a `cmd_clr_nack` pulse. `cmd_clr_iter` leaves it unchanged.
- R8: With inhibit on, a character with a parity error is still written into the holding register (visible on `rx_data`), but `rx_valid` stays low for it.
- R9: With `cfg_limit_nack` high, at most `cfg_max_iter` (0 to 7) error signals are sent in a row. The next bad copy gets no error signal: it is delivered with `rx_valid` high, `iter_flag` is set, and the run count returns to zero. A good character or a suppressed error also resets the run count.
- R10: `iter_flag` is sticky. It clears only on a `cmd_clr_iter` pulse.
- R11: With `cfg_limit_nack` low and inhibit off, every character with a parity error gets an error signal.
- R12: While `rx_valid` is high and `rx_ready` is low, `rx_data` and `rx_valid` hold and new characters are dropped. `rx_valid` falls in the cycle after a handshake unless a new character completes in the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_tick | input | 1 | Time step strobe, `ETU_TICKS` per ETU |
| io_in | input | 1 | Level of the shared I/O line, synchronous to `clk` |
| io_drive_low | output | 1 | Open-drain enable: 1 pulls the line low (error signal) |
| cfg_inhibit_nack | input | 1 | Suppress error signalling |
| cfg_limit_nack | input | 1 | Enable the cap on successive error signals |
| cfg_max_iter | input | 3 | Cap on successive error signals |
| cmd_clr_nack | input | 1 | Pulse: clear `nack_inh_flag` |
| cmd_clr_iter | input | 1 | Pulse: clear `iter_flag` |
| err_cnt_rd | input | 1 | Pulse: read-and-clear of `err_count` |
| err_count | output | 8 | Saturating parity error tally |
| nack_inh_flag | output | 1 | Sticky: an error signal was suppressed |
| iter_flag | output | 1 | Sticky: the successive-error cap was reached |
| rx_data | output | 8 | Holding register contents |
| rx_valid | output | 1 | Holding register offers a character |
| rx_ready | input | 1 | Consumer accepts the held character |

## Verification
The assertions take four things for granted about the inputs:
- `io_in` is already synchronous to `clk`.
- `etu_tick` is a single-cycle strobe.
- Configuration changes only while no character is on the line.
- Command and read inputs are single-cycle pulses.

The stimulus meets these conditions by construction:
- A tick is generated every second clock.
- Every card bit is held for a whole ETU, starting in the cycle before a tick.
- Configuration and commands are changed only between frames, after the three trailing idle ETUs.
- `rx_ready` is raised only in one-cycle pulses between frames.

// File: rtl/t0rx_pkg.sv
package t0rx_pkg;

  // Receive frame sequencer states
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_SHIFT,
    FR_GUARD_H,
    FR_ERR,
    FR_GUARD2
  } fr_state_e;

endpackage

// File: rtl/t0rx_etu_ctr.sv
module t0rx_etu_ctr #(
  parameter int ETU_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic half_hit,
  output logic full_hit
);
  localparam int CW   = $clog2(ETU_TICKS);
  localparam int HALF = ETU_TICKS / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= cnt + CW'(1);
  end

  assign half_hit = tick && (cnt == CW'(HALF - 1));
  assign full_hit = tick && (cnt == CW'(ETU_TICKS - 1));

endmodule

// File: rtl/t0rx_frame.sv
module t0rx_frame
  import t0rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          etu_tick,
  input  logic          io_in,
  input  logic          half_hit,
  input  logic          full_hit,
  input  logic          nack_req,
  output logic          restart,
  output logic          done,
  output logic          par_err,
  output logic [DW-1:0] char_data,
  output logic          io_drive_low
);
  localparam int IW = $clog2(DW + 1);

  fr_state_e     st;
  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          nack_q;
  logic          last_bit;

  assign last_bit     = (idx == IW'(DW));
  assign done         = (st == FR_SHIFT) && full_hit && last_bit;
  assign par_err      = ^{sh, io_in};          // even parity over data + parity bit (R1)
  assign char_data    = sh;
  assign io_drive_low = (st == FR_ERR) && nack_q;  // one ETU in guard time (R3)

  always_comb begin
    case (st)
      FR_IDLE:             restart = 1'b1;
      FR_START, FR_GUARD_H: restart = half_hit;
      default:             restart = full_hit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      sh     <= '0;
      idx    <= '0;
      nack_q <= 1'b0;
    end else begin
      case (st)
        FR_IDLE: if (etu_tick && !io_in) st <= FR_START;
        FR_START: if (half_hit) begin
          idx <= '0;
          st  <= io_in ? FR_IDLE : FR_SHIFT;   // second low sample qualifies start (R2)
        end
        FR_SHIFT: if (full_hit) begin
          if (last_bit) begin
            st     <= FR_GUARD_H;
            nack_q <= nack_req;
          end else begin
            sh  <= {io_in, sh[DW-1:1]};
            idx <= idx + IW'(1);
          end
        end
        FR_GUARD_H: if (half_hit) st <= FR_ERR;
        FR_ERR: if (full_hit) begin
          st     <= FR_GUARD2;
          nack_q <= 1'b0;
        end
        FR_GUARD2: if (full_hit) st <= FR_IDLE;
        default: st <= FR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/t0rx_err_ctl.sv
module t0rx_err_ctl #(
  parameter int CNT_W  = 8,
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              par_err,
  input  logic              cfg_inhibit_nack,
  input  logic              cfg_limit_nack,
  input  logic [ITER_W-1:0] cfg_max_iter,
  input  logic              err_cnt_rd,
  input  logic              cmd_clr_nack,
  input  logic              cmd_clr_iter,
  output logic              nack_req,
  output logic              load,
  output logic              load_valid,
  output logic [CNT_W-1:0]  err_count,
  output logic              nack_inh_flag,
  output logic              iter_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              bad;
  logic              at_limit;
  logic              set_inh;
  logic              set_iter;
  logic [ITER_W-1:0] run;

  always_comb begin
    bad        = done && par_err;
    at_limit   = cfg_limit_nack && (run == cfg_max_iter);
    set_inh    = bad && cfg_inhibit_nack;              // R6
    set_iter   = bad && !cfg_inhibit_nack && at_limit; // R9
    nack_req   = bad && !cfg_inhibit_nack && !at_limit;
    load       = done && !nack_req;
    load_valid = !par_err || set_iter;                 // R8: suppressed error not offered
  end

  // successive error-signal run length (R9, R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (done) begin
      if (nack_req && cfg_limit_nack) run <= run + ITER_W'(1);
      else                            run <= '0;
    end
  end

  // saturating tally, read clears (R4, R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        err_count <= '0;
    else if (err_cnt_rd)               err_count <= bad ? CNT_W'(1) : '0;
    else if (bad && err_count != CNT_MAX) err_count <= err_count + CNT_W'(1);
  end

  // sticky flags (R7, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_inh_flag <= 1'b0;
      iter_flag     <= 1'b0;
    end else begin
      nack_inh_flag <= (nack_inh_flag && !cmd_clr_nack) || set_inh;
      iter_flag     <= (iter_flag && !cmd_clr_iter) || set_iter;
    end
  end

endmodule

// File: rtl/t0rx_hold.sv
module t0rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_valid,
  input  logic [DW-1:0] load_data,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);
  logic free;

  assign free = !rx_valid || rx_ready;

  // single entry; characters arriving while occupied are dropped (R12)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (load && free) begin
      rx_data  <= load_data;
      rx_valid <= load_valid;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/t0_char_rx.sv
module t0_char_rx #(
  parameter int ETU_TICKS = 16,
  parameter int DW        = 8,
  parameter int CNT_W     = 8,
  parameter int ITER_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              etu_tick,
  input  logic              io_in,
  output logic              io_drive_low,
  input  logic              cfg_inhibit_nack,
  input  logic              cfg_limit_nack,
  input  logic [ITER_W-1:0] cfg_max_iter,
  input  logic              cmd_clr_nack,
  input  logic              cmd_clr_iter,
  input  logic              err_cnt_rd,
  output logic [CNT_W-1:0]  err_count,
  output logic              nack_inh_flag,
  output logic              iter_flag,
  output logic [DW-1:0]     rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  logic          half_hit;
  logic          full_hit;
  logic          restart;
  logic          done;
  logic          par_err;
  logic [DW-1:0] char_data;
  logic          nack_req;
  logic          load;
  logic          load_valid;

  t0rx_etu_ctr #(.ETU_TICKS(ETU_TICKS)) etu_i (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .restart(restart),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  t0rx_frame #(.DW(DW)) frame_i (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_in(io_in),
    .half_hit(half_hit), .full_hit(full_hit), .nack_req(nack_req),
    .restart(restart), .done(done), .par_err(par_err),
    .char_data(char_data), .io_drive_low(io_drive_low)
  );

  t0rx_err_ctl #(.CNT_W(CNT_W), .ITER_W(ITER_W)) err_i (
    .clk(clk), .rst_n(rst_n), .done(done), .par_err(par_err),
    .cfg_inhibit_nack(cfg_inhibit_nack), .cfg_limit_nack(cfg_limit_nack),
    .cfg_max_iter(cfg_max_iter), .err_cnt_rd(err_cnt_rd),
    .cmd_clr_nack(cmd_clr_nack), .cmd_clr_iter(cmd_clr_iter),
    .nack_req(nack_req), .load(load), .load_valid(load_valid),
    .err_count(err_count), .nack_inh_flag(nack_inh_flag), .iter_flag(iter_flag)
  );

  t0rx_hold #(.DW(DW)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_valid(load_valid),
    .load_data(char_data), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

endmodule

// File: rtl/t0rx_checker.sv
module t0rx_checker #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             etu_tick,
  input logic             io_drive_low,
  input logic             err_cnt_rd,
  input logic [CNT_W-1:0] err_count,
  input logic             nack_inh_flag,
  input logic             cmd_clr_nack,
  input logic             iter_flag,
  input logic             cmd_clr_iter,
  input logic [DW-1:0]    rx_data,
  input logic             rx_valid,
  input logic             rx_ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // error signal edges fall on ETU step boundaries (R3)
  p_nack_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_drive_low) |-> $past(etu_tick));

  // tally moves by 0 or +1 when not read (R4)
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !err_cnt_rd |=> (err_count == $past(err_count)) ||
                    (err_count == $past(err_count) + CNT_W'(1)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX) && !err_cnt_rd |=> err_count == CNT_MAX);

  // read leaves 0, or 1 when an error coincides (R5)
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_rd |=> err_count <= CNT_W'(1));

  p_inh_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_inh_flag && !cmd_clr_nack |=> nack_inh_flag);

  p_iter_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iter_flag && !cmd_clr_iter |=> iter_flag);

  // back-pressure holds the entry (R12)
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

endmodule

bind t0_char_rx t0rx_checker #(.DW(DW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_drive_low(io_drive_low),
  .err_cnt_rd(err_cnt_rd), .err_count(err_count), .nack_inh_flag(nack_inh_flag),
  .cmd_clr_nack(cmd_clr_nack), .iter_flag(iter_flag), .cmd_clr_iter(cmd_clr_iter),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/t0_char_rx_tb_top.sv
module t0_char_rx_tb_top;
  localparam int ETU_TICKS  = 4;
  localparam int TICK_DIV   = 2;
  localparam int ETU_CLK    = ETU_TICKS * TICK_DIV;
  localparam int FRAME_ETUS = 13;
  localparam int NACK_FIRST = 10 * ETU_CLK + 1;
  localparam int NACK_LAST  = 11 * ETU_CLK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic       etu_tick;
  logic       card_low = 1'b0;
  logic       io_in;
  logic       io_drive_low;
  logic       cfg_inhibit_nack = 1'b0;
  logic       cfg_limit_nack = 1'b0;
  logic [2:0] cfg_max_iter = 3'd0;
  logic       cmd_clr_nack = 1'b0;
  logic       cmd_clr_iter = 1'b0;
  logic       err_cnt_rd = 1'b0;
  logic [7:0] err_count;
  logic       nack_inh_flag;
  logic       iter_flag;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;

  always #4 clk = ~clk;                 // 125 MHz
  always @(posedge clk) phase <= ~phase;
  assign etu_tick = phase;
  assign io_in = !(card_low || io_drive_low);

  t0_char_rx #(.ETU_TICKS(ETU_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_in(io_in),
    .io_drive_low(io_drive_low), .cfg_inhibit_nack(cfg_inhibit_nack),
    .cfg_limit_nack(cfg_limit_nack), .cfg_max_iter(cfg_max_iter),
    .cmd_clr_nack(cmd_clr_nack), .cmd_clr_iter(cmd_clr_iter),
    .err_cnt_rd(err_cnt_rd), .err_count(err_count),
    .nack_inh_flag(nack_inh_flag), .iter_flag(iter_flag),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference model state
  int         exp_cnt = 0;
  int         exp_run = 0;
  bit         exp_inh = 1'b0;
  bit         exp_iter = 1'b0;
  bit         exp_valid = 1'b0;
  logic [7:0] exp_data = 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] d, input bit bad, input int b);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    if (b == 9) return (^d) ^ bad;
    return 1'b1;
  endfunction

  task automatic model_load(input logic [7:0] d, input bit v);
    if (!exp_valid) begin
      exp_data  = d;
      exp_valid = v;
    end
  endtask

  task automatic model_char(input logic [7:0] d, input bit bad, output bit exp_nack);
    exp_nack = 1'b0;
    if (!bad) begin
      model_load(d, 1'b1);
      exp_run = 0;
    end else begin
      if (exp_cnt != 255) exp_cnt++;
      if (cfg_inhibit_nack) begin
        exp_inh = 1'b1;
        model_load(d, 1'b0);
        exp_run = 0;
      end else if (cfg_limit_nack && exp_run == int'(cfg_max_iter)) begin
        exp_iter = 1'b1;
        model_load(d, 1'b1);
        exp_run = 0;
      end else begin
        exp_nack = 1'b1;
        exp_run  = cfg_limit_nack ? exp_run + 1 : 0;
      end
    end
  endtask

  task automatic sync_tick;
    @(negedge clk);
    while (phase != 1'b1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad,
                            output int first, output int last, output int cnt);
    first = -1; last = -1; cnt = 0;
    sync_tick();
    for (int b = 0; b < FRAME_ETUS; b++) begin
      for (int c = 0; c < ETU_CLK; c++) begin
        card_low = !frame_bit(d, bad, b);
        if (io_drive_low) begin
          if (first < 0) first = b * ETU_CLK + c;
          last = b * ETU_CLK + c;
          cnt++;
        end
        @(negedge clk);
      end
    end
    card_low = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk(int'(err_count) == exp_cnt, req, "err_count", err_count, exp_cnt);
    chk(nack_inh_flag == exp_inh, req, "nack_inh_flag", nack_inh_flag, exp_inh);
    chk(iter_flag == exp_iter, req, "iter_flag", iter_flag, exp_iter);
    chk(rx_valid == exp_valid, req, "rx_valid", rx_valid, exp_valid);
    chk(rx_data == exp_data, req, "rx_data", rx_data, exp_data);
  endtask

  task automatic run_char(input string req, input logic [7:0] d, input bit bad);
    bit en;
    int f, l, n;
    model_char(d, bad, en);
    send_frame(d, bad, f, l, n);
    chk((n > 0) == en, req, "error signal present", n > 0, en);
    if (en) begin
      chk(f == NACK_FIRST, req, "error signal start", f, NACK_FIRST);
      chk(l == NACK_LAST, req, "error signal end", l, NACK_LAST);
    end
    check_state(req);
  endtask

  task automatic consume;
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    exp_valid = 1'b0;
    chk(rx_valid == 1'b0, "R12", "rx_valid after handshake", rx_valid, 0);
  endtask

  task automatic read_err;
    @(negedge clk) err_cnt_rd = 1'b1;
    @(negedge clk) err_cnt_rd = 1'b0;
    exp_cnt = 0;
    chk(err_count == 8'd0, "R5", "err_count after read", err_count, 0);
  endtask

  task automatic clr_nack;
    @(negedge clk) cmd_clr_nack = 1'b1;
    @(negedge clk) cmd_clr_nack = 1'b0;
    exp_inh = 1'b0;
  endtask

  task automatic clr_iter;
    @(negedge clk) cmd_clr_iter = 1'b1;
    @(negedge clk) cmd_clr_iter = 1'b0;
    exp_iter = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7105));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(rx_valid == 1'b0, "R12", "reset rx_valid", rx_valid, 0);
    chk(err_count == 8'd0, "R4", "reset err_count", err_count, 0);
    chk(io_drive_low == 1'b0, "R3", "reset io_drive_low", io_drive_low, 0);
    chk(nack_inh_flag == 1'b0, "R6", "reset nack_inh_flag", nack_inh_flag, 0);
    chk(iter_flag == 1'b0, "R10", "reset iter_flag", iter_flag, 0);

    // R1: good characters
    run_char("R1", 8'hA5, 1'b0);
    consume();
    run_char("R1", 8'h01, 1'b0);
    consume();
    // R3 / R11: bad character with default config gets error signal
    run_char("R3", 8'h3C, 1'b1);
    run_char("R11", 8'hFF, 1'b1);
    run_char("R11", 8'h00, 1'b1);
    // R2: short low glitch
    begin
      int f, l, n;
      f = -1; n = 0;
      sync_tick();
      card_low = 1'b1;
      repeat (2) @(negedge clk);
      card_low = 1'b0;
      for (int c = 0; c < FRAME_ETUS * ETU_CLK; c++) begin
        if (io_drive_low) n++;
        @(negedge clk);
      end
      chk(n == 0, "R2", "error signal after glitch", n, 0);
      check_state("R2");
      l = f;
    end
    // R5: read clears
    read_err();
    // R6 / R8: inhibit
    cfg_inhibit_nack = 1'b1;
    run_char("R6", 8'h5A, 1'b1);
    chk(rx_data == 8'h5A, "R8", "rx_data of suppressed char", rx_data, 8'h5A);
    chk(rx_valid == 1'b0, "R8", "rx_valid of suppressed char", rx_valid, 0);
    // R7: only the matching command clears the flag
    clr_iter();
    chk(nack_inh_flag == 1'b1, "R7", "flag after other command", nack_inh_flag, 1);
    clr_nack();
    chk(nack_inh_flag == 1'b0, "R7", "flag after clear command", nack_inh_flag, 0);
    cfg_inhibit_nack = 1'b0;
    // R9: cap of two successive error signals
    cfg_limit_nack = 1'b1;
    cfg_max_iter = 3'd2;
    run_char("R9", 8'h11, 1'b1);
    run_char("R9", 8'h11, 1'b1);
    run_char("R9", 8'h22, 1'b0);
    consume();
    run_char("R9", 8'h33, 1'b1);
    run_char("R9", 8'h33, 1'b1);
    run_char("R9", 8'h33, 1'b1);
    consume();
    // R10: sticky until its own command
    clr_nack();
    chk(iter_flag == 1'b1, "R10", "iter_flag after other command", iter_flag, 1);
    clr_iter();
    chk(iter_flag == 1'b0, "R10", "iter_flag after clear command", iter_flag, 0);
    cfg_max_iter = 3'd0;
    run_char("R9", 8'h44, 1'b1);
    consume();
    cfg_limit_nack = 1'b0;
    // R12: back-pressure drops the second character
    run_char("R12", 8'h96, 1'b0);
    run_char("R12", 8'h69, 1'b0);
    chk(rx_data == 8'h96, "R12", "held data under back-pressure", rx_data, 8'h96);
    consume();

    // random phase
    for (int i = 0; i < 150; i++) begin
      logic [7:0] d;
      bit bad;
      if ($urandom_range(0, 9) < 2) begin
        cfg_inhibit_nack = ($urandom_range(0, 4) == 0);
        cfg_limit_nack   = $urandom_range(0, 1);
        cfg_max_iter     = 3'($urandom_range(0, 3));
      end
      if (exp_valid && $urandom_range(0, 9) < 6) consume();
      if ($urandom_range(0, 9) == 0) read_err();
      if ($urandom_range(0, 9) == 0) clr_nack();
      if ($urandom_range(0, 9) == 0) clr_iter();
      d = 8'($urandom);
      bad = ($urandom_range(0, 9) < 4);
      run_char(bad ? "R4" : "R1", d, bad);
    end

    // R4: saturation
    cfg_inhibit_nack = 1'b1;
    if (exp_valid) consume();
    read_err();
    for (int i = 0; i < 257; i++) run_char("R4", 8'($urandom), 1'b1);
    chk(err_count == 8'd255, "R4", "saturated err_count", err_count, 255);
    read_err();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule